// File: doc/BRIEF.md
# Always-On Tick Timer with Alarms and Capture

This block is a free-running up-counter for an always-on power domain. A counter-enable input advances it by one per clock, so the clock and enable together set the tick rate. Two alarm channels compare the counter against programmable thresholds and raise a wakeup event once per arming. The counter wrapping back to zero raises an overflow event.

Software can snapshot the counter value into a pair of readable capture buffers. It does this either with a self-clearing request bit or by letting selected system event strobes trigger the snapshot. The buffers are filled in turn, so the two most recent snapshots can always be read back.

Both event sources, wakeup and overflow, feed two independent interrupt groups. One group serves the main processor and the other a low-power coprocessor. Each group has its own raw, status, enable and clear registers and drives its own interrupt line. All registers sit on a simple word-addressed register bus with a single-cycle write strobe and combinational read data.

Top module: `aon_tick_timer`

## Requirements
- R1: After reset the counter holds RST_VAL (default 0). It advances by one on every clock edge where `tick_en` is 1 and holds its value otherwise.
- R2: Alarm channel k has its threshold low word at word address 2k and its high part at address 2k+1. The high part holds threshold bits [CNT_W-1:32] in bits [CNT_W-33:0] and the arm bit at bit 31. Write data above the field is dropped, and all of these read back as written.
- R3: An armed channel fires on the first clock edge where the counter is greater than or equal to its threshold. On that edge it sets the raw wakeup bit (bit 31) in both groups and clears its own arm bit, so it fires only once.
- R4: A channel whose arm bit is 0 never sets the raw wakeup bit, whatever its threshold.
- R5: A counter step from all-ones to zero sets the raw overflow bit (bit 30) in both groups on that same edge.
- R6: Writing 1 to bit 27 of the capture control register (address 4) copies the current counter into a buffer. Bit 27 reads back as 0, while select bits [31:28] hold their written values.
- R7: Select bits 31, 30, 29 and 28 make the strobes `ev_core_rst_done`, `ev_cpu_stall`, `ev_xtal_up` and `ev_dma_busy` trigger a capture. A strobe whose select bit is 0 changes no buffer and does not advance the buffer order.
- R8: Captures go to buffer 0 first after reset, then alternate with buffer 1. Buffer j has its low word at address 5+2j and its high part in the low bits of address 6+2j.
- R9: In each group the status register is raw AND enable. The group's interrupt line is 1 exactly when any status bit is 1. Only bits 31 and 30 of the enable register are kept. Every register is 0 after reset.
- R10: Writing 1 to a bit of a group's clear register clears that raw bit. If hardware sets the same bit on the same edge, the bit stays 1.
- R11: The main group (raw 9, status 10, enable 11, clear 12) and the coprocessor group (raw 13, status 14, enable 15, clear 16) are enabled and cleared independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable |
| ev_dma_busy | input | 1 | Register-transfer engine activity strobe |
| ev_xtal_up | input | 1 | Crystal clock power-up strobe |
| ev_cpu_stall | input | 1 | Processor stall entry/exit strobe |
| ev_core_rst_done | input | 1 | Digital core reset completion strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| irq_main | output | 1 | Main processor interrupt |
| irq_lp | output | 1 | Coprocessor interrupt |

## Verification
The bench builds the block with CNT_W set to 40 and RST_VAL set to 2^40-48. The narrower high field shows that write bits above the field are dropped. Starting just below the top of the range brings the all-ones-to-zero wrap within a few dozen ticks, where the default 48-bit zero start would never reach it. Thresholds near that start value let alarms fire on exact edges, and a clear is placed on the very edge an alarm fires to show that the set wins.

// File: rtl/aon_tmr_pkg.sv
package aon_tmr_pkg;
   // interrupt source bit positions, shared by raw/status/enable/clear
   localparam int WAKE_BIT = 31;
   localparam int OVF_BIT  = 30;
   // alarm high word arm bit
   localparam int ARM_BIT  = 31;
   // capture control
   localparam int CAP_REQ_BIT = 27;
   localparam int SEL_LSB     = 28;
   localparam int NUM_EVT     = 4;
   // register offsets inside one interrupt group
   localparam int GRP_RAW  = 0;
   localparam int GRP_STAT = 1;
   localparam int GRP_EN   = 2;
   localparam int GRP_CLR  = 3;
   localparam int GRP_SPAN = 4;
   localparam int NUM_GRP  = 2;
endpackage

// File: rtl/aon_cnt.sv
module aon_cnt #(
   parameter int              CNT_W   = 48,
   parameter logic [CNT_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= RST_VAL;
      else if (tick_en) cnt_q <= cnt_q + CNT_W'(1);
   end

   // the step taken on this edge lands on zero
   assign wrap_o = tick_en & (&cnt_q);
endmodule

// File: rtl/aon_alarm.sv
module aon_alarm #(
   parameter int CNT_W = 48,
   localparam int HI_W = CNT_W - 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [31:0]      wdata_lo,
   input  logic [HI_W-1:0]  wdata_hi,
   input  logic             wdata_arm,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] thr_o,
   output logic             arm_o,
   output logic             fire_o
);
   assign fire_o = arm_o && (cnt >= thr_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_o <= '0;
         arm_o <= 1'b0;
      end else begin
         if (wr_lo) thr_o[31:0] <= wdata_lo;
         if (wr_hi) begin
            thr_o[CNT_W-1:32] <= wdata_hi;
            arm_o             <= wdata_arm;
         end else if (fire_o) begin
            arm_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/aon_capture.sv
module aon_capture #(
   parameter int CNT_W   = 48,
   parameter int NUM_BUF = 2,
   localparam int PTR_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            trig,
   input  logic [CNT_W-1:0]                cnt,
   output logic [NUM_BUF-1:0][CNT_W-1:0]   buf_o,
   output logic [PTR_W-1:0]                ptr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_o <= '0;
         ptr_o <= '0;
      end else if (trig) begin
         buf_o[ptr_o] <= cnt;
         ptr_o        <= (ptr_o == PTR_W'(NUM_BUF - 1)) ? '0 : ptr_o + PTR_W'(1);
      end
   end
endmodule

// File: rtl/aon_irq_grp.sv
module aon_irq_grp (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] set,      // [1] wakeup, [0] overflow
   input  logic       en_wr,
   input  logic       clr_wr,
   input  logic [1:0] wbits,    // write data bits 31:30
   output logic [1:0] raw_o,
   output logic [1:0] en_o,
   output logic [1:0] stat_o,
   output logic       irq_o
);
   logic [1:0] clr_mask;
   assign clr_mask = clr_wr ? wbits : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_o <= '0;
         en_o  <= '0;
      end else begin
         raw_o <= (raw_o & ~clr_mask) | set;   // hardware set wins
         if (en_wr) en_o <= wbits;
      end
   end

   assign stat_o = raw_o & en_o;
   assign irq_o  = |stat_o;
endmodule

// File: rtl/aon_tick_timer.sv
module aon_tick_timer
   import aon_tmr_pkg::*;
#(
   parameter int               CNT_W     = 48,
   parameter logic [CNT_W-1:0] RST_VAL   = '0,
   parameter int               NUM_ALARM = 2,
   parameter int               NUM_BUF   = 2,
   parameter int               ADDR_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              ev_dma_busy,
   input  logic              ev_xtal_up,
   input  logic              ev_cpu_stall,
   input  logic              ev_core_rst_done,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_main,
   output logic              irq_lp
);
   localparam int HI_W     = CNT_W - 32;
   localparam int A_CAP    = 2 * NUM_ALARM;
   localparam int BUF_BASE = A_CAP + 1;
   localparam int GRP_BASE = BUF_BASE + 2 * NUM_BUF;
   localparam int A_LAST   = GRP_BASE + NUM_GRP * GRP_SPAN - 1;
   localparam int PTR_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;

   generate
      if (CNT_W < 33 || CNT_W > 48) begin : g_bad_cnt_w
         $error("CNT_W must lie in 33..48");
      end
      if (NUM_ALARM < 1 || NUM_BUF < 1) begin : g_bad_count
         $error("NUM_ALARM and NUM_BUF must be at least 1");
      end
      if (A_LAST >= (1 << ADDR_W)) begin : g_bad_addr_w
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   // counter
   logic [CNT_W-1:0] cnt;
   logic             wrap;
   aon_cnt #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_q(cnt), .wrap_o(wrap)
   );

   // alarm channels
   logic [NUM_ALARM-1:0]            arm, fire;
   logic [NUM_ALARM-1:0][CNT_W-1:0] thr;
   for (genvar i = 0; i < NUM_ALARM; i++) begin : g_alm
      aon_alarm #(.CNT_W(CNT_W)) u_alm (
         .clk(clk), .rst_n(rst_n),
         .wr_lo(bus_wr && bus_addr == ADDR_W'(2 * i)),
         .wr_hi(bus_wr && bus_addr == ADDR_W'(2 * i + 1)),
         .wdata_lo(bus_wdata), .wdata_hi(bus_wdata[HI_W-1:0]),
         .wdata_arm(bus_wdata[ARM_BIT]),
         .cnt(cnt), .thr_o(thr[i]), .arm_o(arm[i]), .fire_o(fire[i])
      );
   end

   // capture control and buffers
   logic [NUM_EVT-1:0]              sel_q, evt;
   logic                            cap_wr, cap_fire;
   logic [NUM_BUF-1:0][CNT_W-1:0]   bufv;
   logic [PTR_W-1:0]                cap_ptr;

   assign evt      = {ev_core_rst_done, ev_cpu_stall, ev_xtal_up, ev_dma_busy};
   assign cap_wr   = bus_wr && bus_addr == ADDR_W'(A_CAP);
   assign cap_fire = (cap_wr && bus_wdata[CAP_REQ_BIT]) || |(sel_q & evt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (cap_wr) sel_q <= bus_wdata[SEL_LSB +: NUM_EVT];
   end

   aon_capture #(.CNT_W(CNT_W), .NUM_BUF(NUM_BUF)) u_cap (
      .clk(clk), .rst_n(rst_n), .trig(cap_fire), .cnt(cnt),
      .buf_o(bufv), .ptr_o(cap_ptr)
   );

   // interrupt groups: 0 = main processor, 1 = coprocessor
   logic [NUM_GRP-1:0][1:0] raw_g, en_g, stat_g;
   logic [NUM_GRP-1:0]      irq_g;
   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      aon_irq_grp u_grp (
         .clk(clk), .rst_n(rst_n),
         .set({|fire, wrap}),
         .en_wr(bus_wr && bus_addr == ADDR_W'(GRP_BASE + g * GRP_SPAN + GRP_EN)),
         .clr_wr(bus_wr && bus_addr == ADDR_W'(GRP_BASE + g * GRP_SPAN + GRP_CLR)),
         .wbits({bus_wdata[WAKE_BIT], bus_wdata[OVF_BIT]}),
         .raw_o(raw_g[g]), .en_o(en_g[g]), .stat_o(stat_g[g]), .irq_o(irq_g[g])
      );
   end
   assign irq_main = irq_g[0];
   assign irq_lp   = irq_g[1];

   // read mux
   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_ALARM; i++) begin
         if (bus_addr == ADDR_W'(2 * i)) bus_rdata = thr[i][31:0];
         if (bus_addr == ADDR_W'(2 * i + 1)) begin
            bus_rdata[HI_W-1:0] = thr[i][CNT_W-1:32];
            bus_rdata[ARM_BIT]  = arm[i];
         end
      end
      if (bus_addr == ADDR_W'(A_CAP)) bus_rdata[SEL_LSB +: NUM_EVT] = sel_q;
      for (int j = 0; j < NUM_BUF; j++) begin
         if (bus_addr == ADDR_W'(BUF_BASE + 2 * j)) bus_rdata = bufv[j][31:0];
         if (bus_addr == ADDR_W'(BUF_BASE + 2 * j + 1))
            bus_rdata[HI_W-1:0] = bufv[j][CNT_W-1:32];
      end
      for (int g = 0; g < NUM_GRP; g++) begin
         if (bus_addr == ADDR_W'(GRP_BASE + g * GRP_SPAN + GRP_RAW))
            {bus_rdata[WAKE_BIT], bus_rdata[OVF_BIT]} = raw_g[g];
         if (bus_addr == ADDR_W'(GRP_BASE + g * GRP_SPAN + GRP_STAT))
            {bus_rdata[WAKE_BIT], bus_rdata[OVF_BIT]} = stat_g[g];
         if (bus_addr == ADDR_W'(GRP_BASE + g * GRP_SPAN + GRP_EN))
            {bus_rdata[WAKE_BIT], bus_rdata[OVF_BIT]} = en_g[g];
      end
   end
endmodule

// File: rtl/aon_tick_timer_chk.sv
module aon_tick_timer_chk #(
   parameter int CNT_W     = 48,
   parameter int NUM_ALARM = 2,
   parameter int PTR_W     = 1,
   parameter int ADDR_W    = 5,
   parameter int GRP_BASE  = 9
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            tick_en,
   input logic                            bus_wr,
   input logic [ADDR_W-1:0]               bus_addr,
   input logic [31:0]                     bus_wdata,
   input logic [CNT_W-1:0]                cnt,
   input logic [NUM_ALARM-1:0]            arm,
   input logic [NUM_ALARM-1:0][CNT_W-1:0] thr,
   input logic [1:0]                      raw_m,
   input logic [1:0]                      raw_l,
   input logic                            cap_fire,
   input logic [PTR_W-1:0]                cap_ptr
);
   // R1
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(cnt));

   // R1
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> cnt == $past(cnt) + CNT_W'(1));

   // R5
   ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && &cnt) |=> (raw_m[0] && raw_l[0]));

   for (genvar i = 0; i < NUM_ALARM; i++) begin : g_alm_chk
      // R3
      alarm_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (arm[i] && cnt >= thr[i] && !(bus_wr && bus_addr == ADDR_W'(2 * i + 1)))
         |=> (!arm[i] && raw_m[1] && raw_l[1]));
   end

   // R4
   wake_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_m[1]) |-> $past(|arm));

   // R8
   cap_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_fire |=> cap_ptr != $past(cap_ptr));

   // R10
   raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_m[1] && !(bus_wr && bus_addr == ADDR_W'(GRP_BASE + 3) && bus_wdata[31]))
      |=> raw_m[1]);
endmodule

bind aon_tick_timer aon_tick_timer_chk #(
   .CNT_W(CNT_W), .NUM_ALARM(NUM_ALARM), .PTR_W(PTR_W),
   .ADDR_W(ADDR_W), .GRP_BASE(GRP_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
   .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .cnt(cnt), .arm(arm), .thr(thr),
   .raw_m(raw_g[0]), .raw_l(raw_g[1]),
   .cap_fire(cap_fire), .cap_ptr(cap_ptr)
);

// File: tb/aon_tick_timer_tb.sv
module aon_tick_timer_tb;
   localparam int         CW   = 40;
   localparam logic [CW-1:0] RSTV = {CW{1'b1}} - CW'(47);   // 2^40-48

   // register word addresses
   localparam logic [4:0] A0_LO = 0, A0_HI = 1, A1_LO = 2, A1_HI = 3, CAP = 4;
   localparam logic [4:0] B0_LO = 5, B0_HI = 6, B1_LO = 7, B1_HI = 8;
   localparam logic [4:0] M_RAW = 9, M_ST = 10, M_EN = 11, M_CLR = 12;
   localparam logic [4:0] L_RAW = 13, L_EN = 15, L_CLR = 16;

   logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
   logic ev_dma = 1'b0, ev_xtal = 1'b0, ev_stall = 1'b0, ev_rst = 1'b0;
   logic bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic irq_main, irq_lp;

   int total = 0, bad = 0;
   logic [CW-1:0] cnt_m = RSTV;
   logic [31:0]   rv;

   always #4 clk = ~clk;   // 125 MHz

   aon_tick_timer #(.CNT_W(CW), .RST_VAL(RSTV)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .ev_dma_busy(ev_dma), .ev_xtal_up(ev_xtal), .ev_cpu_stall(ev_stall),
      .ev_core_rst_done(ev_rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_main(irq_main), .irq_lp(irq_lp)
   );

   typedef struct packed {
      logic        rd;     // 0 write, 1 read and compare
      logic [4:0]  addr;
      logic [31:0] data;   // write data or expected read data
      logic [7:0]  req;
   } step_t;

   // reset state (R9), field readback (R2), request bit and capture (R6)
   localparam int NSTEP = 17;
   localparam step_t TBL [NSTEP] = '{
      '{1'b1, M_RAW, 32'h0, 8'd9},
      '{1'b1, L_RAW, 32'h0, 8'd9},
      '{1'b1, B0_LO, 32'h0, 8'd9},
      '{1'b0, A0_LO, 32'h1234_5678, 8'd2},
      '{1'b1, A0_LO, 32'h1234_5678, 8'd2},
      '{1'b0, A0_HI, 32'h0000_00AB, 8'd2},
      '{1'b1, A0_HI, 32'h0000_00AB, 8'd2},
      '{1'b0, A1_HI, 32'h0000_FF5A, 8'd2},
      '{1'b1, A1_HI, 32'h0000_005A, 8'd2},
      '{1'b0, M_EN,  32'hFFFF_FFFF, 8'd9},
      '{1'b1, M_EN,  32'hC000_0000, 8'd9},
      '{1'b0, M_EN,  32'h0, 8'd9},
      '{1'b0, CAP,   32'hF800_0000, 8'd6},
      '{1'b1, CAP,   32'hF000_0000, 8'd6},
      '{1'b1, B0_LO, 32'hFFFF_FFD0, 8'd6},
      '{1'b1, B0_HI, 32'h0000_00FF, 8'd6},
      '{1'b0, CAP,   32'h0, 8'd6}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic tick(input int n);
      tick_en = 1'b1;
      repeat (n) begin
         @(negedge clk);
         cnt_m = cnt_m + CW'(1);
      end
      tick_en = 1'b0;
   endtask

   task automatic chk_reg(input string req, input logic [4:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9", {31'b0, irq_main | irq_lp}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int s = 0; s < NSTEP; s++) begin
         if (TBL[s].rd) begin
            rd(TBL[s].addr, rv);
            check($sformatf("R%0d step %0d", TBL[s].req, s), rv, TBL[s].data);
         end else begin
            wr(TBL[s].addr, TBL[s].data);
         end
      end

      // R1 and R8: five ticks then a request lands in buffer 1
      tick(5);
      wr(CAP, 32'h0800_0000);
      chk_reg("R8", B1_LO, cnt_m[31:0]);
      chk_reg("R1", B1_HI, {24'b0, cnt_m[39:32]});
      chk_reg("R8", B0_LO, 32'hFFFF_FFD0);

      // R7: only the crystal strobe is selected
      wr(CAP, 32'h2000_0000);
      ev_dma = 1'b1; ev_stall = 1'b1; ev_rst = 1'b1;
      @(negedge clk);
      ev_dma = 1'b0; ev_stall = 1'b0; ev_rst = 1'b0;
      chk_reg("R7", B0_LO, 32'hFFFF_FFD0);
      tick(2);
      ev_xtal = 1'b1;
      @(negedge clk);
      ev_xtal = 1'b0;
      chk_reg("R7", B0_LO, cnt_m[31:0]);
      chk_reg("R8", B1_LO, 32'hFFFF_FFD5);
      wr(CAP, 32'h0);

      // R4: disarmed channel below the counter
      wr(A1_LO, 32'hFFFF_FFD0);
      wr(A1_HI, 32'h0000_00FF);
      wr(M_EN, 32'hC000_0000);
      repeat (3) @(negedge clk);
      chk_reg("R4", M_RAW, 32'h0);
      check("R4", {31'b0, irq_main}, 32'h0);

      // R3: threshold five counts above the counter
      wr(A0_LO, cnt_m[31:0] + 32'd5);
      wr(A0_HI, 32'h8000_00FF);
      tick(5);
      chk_reg("R3", M_RAW, 32'h0);
      @(negedge clk);
      chk_reg("R3", M_RAW, 32'h8000_0000);
      check("R9", {31'b0, irq_main}, 32'h1);
      chk_reg("R3", A0_HI, 32'h0000_00FF);
      chk_reg("R3", L_RAW, 32'h8000_0000);
      check("R11", {31'b0, irq_lp}, 32'h0);

      // R10 and R11: clears act per group
      wr(M_CLR, 32'h8000_0000);
      chk_reg("R10", M_RAW, 32'h0);
      chk_reg("R11", L_RAW, 32'h8000_0000);
      wr(L_CLR, 32'h8000_0000);
      chk_reg("R10", L_RAW, 32'h0);

      // R10: clear on the edge the alarm fires, set wins
      wr(A1_HI, 32'h8000_00FF);
      wr(M_CLR, 32'h8000_0000);
      chk_reg("R10", M_RAW, 32'h8000_0000);
      chk_reg("R3", A1_HI, 32'h0000_00FF);
      wr(M_CLR, 32'h8000_0000);
      wr(L_CLR, 32'h8000_0000);
      chk_reg("R10", M_RAW, 32'h0);

      // R5: run up to all-ones, then wrap
      tick(int'({CW{1'b1}} - cnt_m));
      chk_reg("R5", M_RAW, 32'h0);
      tick(1);
      chk_reg("R5", M_RAW, 32'h4000_0000);
      chk_reg("R5", L_RAW, 32'h4000_0000);
      chk_reg("R9", M_ST, 32'h4000_0000);
      check("R9", {31'b0, irq_main}, 32'h1);
      wr(CAP, 32'h0800_0000);
      chk_reg("R5", B1_LO, 32'h0);
      chk_reg("R5", B1_HI, 32'h0);
      wr(M_EN, 32'h0);
      chk_reg("R9", M_ST, 32'h0);
      check("R9", {31'b0, irq_main}, 32'h0);
      chk_reg("R11", L_EN, 32'h0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule